// File: doc/BRIEF.md
# Bang-Bang Clock Recovery Phase Controller

This block is the digital loop of a clock and data recovery circuit that samples the line twice per symbol: once in the middle of the bit (data sample) and once on the boundary between bits (edge sample). External slicers deliver both samples together with a strobe, once per symbol. From the current data bit, the data bit before it and the edge sample between them, the block decides whether its sampling clock is early, late or carries no timing information. It then moves a phase code by one position, which an external phase interpolator turns into the data and edge sampling clocks.

The loop is first order. Each decision, or each filtered group of decisions, moves the phase code directly, and there is no frequency path. An optional vote filter collects a programmable number of decisions and issues a single step only when the net count passes a programmable threshold. The phase code wraps in both directions, so the loop can follow a constant frequency offset forever. A lock flag shows that the loop is dithering about its target, which means its steps keep reversing direction.

Top module: `cdr_bb_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block loads `phase_code` with `init_code`, clears both step pulses and `locked`, empties the vote window and forgets the previous data bit.
- R2: The first strobed sample after reset only records its data bit as the previous bit. It causes no step and does not count toward a vote window.
- R3: A strobed sample whose data bit equals the previous data bit has no transition. Its decision is hold.
- R4: A strobed sample with a transition whose edge sample equals the previous data bit means the clock is early. Without the vote filter, `phase_code` rises by one at that same clock edge and `step_up` pulses for one cycle.
- R5: A strobed sample with a transition whose edge sample equals the current data bit means the clock is late. Without the vote filter, `phase_code` falls by one at that same clock edge and `step_dn` pulses for one cycle.
- R6: `phase_code` (8 bits by default) wraps modulo 2^8: one step up from 255 gives 0, and one step down from 0 gives 255.
- R7: A cycle with `sample_vld` low causes no step and leaves the stored previous data bit unchanged.
- R8: With `vote_en` high, each window spans `vote_len` decisions (a value of 0 acts as 1), and a hold counts as 0. At the edge of the last sample in the window, the block steps up if the net count (early minus late) is greater than `vote_thresh`, and steps down if it is below minus `vote_thresh`. No step is issued on any other sample.
- R9: A net count exactly equal to plus or minus `vote_thresh` gives no step. Every window starts from an empty count.
- R10: With `vote_en` low, every non-hold decision produces its own step.
- R11: `locked` rises once LOCK_N steps in a row (4 by default) have each reversed the direction of the step before them. A step in the same direction as the step before it clears `locked`.
- R12: Between consecutive cycles `phase_code` changes by exactly +1 with `step_up`, by exactly -1 with `step_dn`, and not at all otherwise. `step_up` and `step_dn` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_code | input | PW | Phase code loaded during reset |
| vote_en | input | 1 | 1 = vote filter active, 0 = one step per decision |
| vote_len | input | CW | Decisions per vote window (0 acts as 1) |
| vote_thresh | input | CW | Net count that must be exceeded before a step |
| sample_vld | input | 1 | Strobe: a new data/edge sample pair is present |
| data_smp | input | 1 | Mid-bit data sample |
| edge_smp | input | 1 | Edge sample taken between the previous and current bit |
| phase_code | output | PW | Phase interpolator code |
| step_up | output | 1 | One-cycle pulse: phase code was incremented |
| step_dn | output | 1 | One-cycle pulse: phase code was decremented |
| locked | output | 1 | Loop is dithering with alternating steps |

## Verification
The bench drives the first sample after reset with a transition relative to a zero bit. A design that skipped priming would take a spurious step there. It holds the strobe low while presenting a different data bit, then sends a sample that has a transition only if that ignored bit had been stored. This catches a design that latches data without the strobe. The wrap tests start at 255 and at 0, so a saturating or mis-sized accumulator would stick at the end of the range. The vote tests use a window whose net count exactly equals the threshold, and follow a full window with a window of the opposite sign. An off-by-one comparison, or a window that does not clear, shows up as a missing or extra step. The lock test stops after three reversals, then adds a fourth and a same-direction step, which checks both the count needed to set the flag and the rule that clears it.

// File: rtl/cdr_bb_pkg.sv
package cdr_bb_pkg;

   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_UP   = 2'b01,
      STEP_DN   = 2'b10
   } step_e;

endpackage

// File: rtl/cdr_bb_detect.sv
// Phase detector: turns a (data, previous data, edge) triple into a step decision.
module cdr_bb_detect
   import cdr_bb_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  vld_i,
   input  logic  data_i,
   input  logic  edge_i,
   output step_e dec_o,
   output logic  dec_vld_o
);

   logic prev_q;
   logic primed_q;
   logic trans;

   always_ff @(posedge clk) begin
      if (rst) begin
         prev_q   <= 1'b0;
         primed_q <= 1'b0;
      end else if (vld_i) begin
         prev_q   <= data_i;
         primed_q <= 1'b1;
      end
   end

   assign trans     = (data_i != prev_q);
   assign dec_vld_o = vld_i && primed_q;

   always_comb begin
      dec_o = STEP_HOLD;
      if (dec_vld_o && trans) begin
         // edge matches the old bit: the boundary lies after the edge clock
         dec_o = (edge_i == prev_q) ? STEP_UP : STEP_DN;
      end
   end

endmodule

// File: rtl/cdr_bb_vote.sv
// Optional majority filter over a window of decisions.
module cdr_bb_vote
   import cdr_bb_pkg::*;
#(
   parameter int CW       = 6,
   parameter bit HAS_VOTE = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          en_i,
   input  logic [CW-1:0] len_i,
   input  logic [CW-1:0] thresh_i,
   input  logic          dec_vld_i,
   input  step_e         dec_i,
   output step_e         cmd_o
);

   localparam int AW = CW + 2;

   generate
      if (HAS_VOTE) begin : g_vote
         logic signed [AW-1:0] acc_q;
         logic [CW-1:0]        cnt_q;
         logic [CW-1:0]        eff_len;
         logic                 last;
         logic signed [AW-1:0] delta;
         logic signed [AW-1:0] sum;
         logic signed [AW-1:0] thr;

         assign eff_len = (len_i == '0) ? CW'(1) : len_i;
         assign last    = (cnt_q == eff_len - CW'(1));
         assign thr     = $signed({2'b00, thresh_i});

         always_comb begin
            case (dec_i)
               STEP_UP: delta = AW'(1);
               STEP_DN: delta = -AW'(1);
               default: delta = '0;
            endcase
         end

         assign sum = acc_q + delta;

         always_ff @(posedge clk) begin
            if (rst || !en_i) begin
               acc_q <= '0;
               cnt_q <= '0;
            end else if (dec_vld_i) begin
               if (last) begin
                  acc_q <= '0;
                  cnt_q <= '0;
               end else begin
                  acc_q <= sum;
                  cnt_q <= cnt_q + CW'(1);
               end
            end
         end

         always_comb begin
            cmd_o = STEP_HOLD;
            if (!en_i) begin
               cmd_o = dec_i;
            end else if (dec_vld_i && last) begin
               if (sum > thr)       cmd_o = STEP_UP;
               else if (sum < -thr) cmd_o = STEP_DN;
            end
         end
      end else begin : g_bypass
         logic unused_in;
         assign unused_in = ^{clk, rst, en_i, len_i, thresh_i, dec_vld_i};
         assign cmd_o     = dec_i;
      end
   endgenerate

endmodule

// File: rtl/cdr_bb_accum.sv
// Wrapping phase accumulator with registered step pulses.
module cdr_bb_accum
   import cdr_bb_pkg::*;
#(
   parameter int PW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] init_i,
   input  step_e         cmd_i,
   output logic [PW-1:0] phase_o,
   output logic          up_o,
   output logic          dn_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_o <= init_i;
         up_o    <= 1'b0;
         dn_o    <= 1'b0;
      end else begin
         up_o <= (cmd_i == STEP_UP);
         dn_o <= (cmd_i == STEP_DN);
         case (cmd_i)
            STEP_UP: phase_o <= phase_o + PW'(1);
            STEP_DN: phase_o <= phase_o - PW'(1);
            default: phase_o <= phase_o;
         endcase
      end
   end

endmodule

// File: rtl/cdr_bb_lock.sv
// Lock flag: counts consecutive direction reversals of the step stream.
module cdr_bb_lock
   import cdr_bb_pkg::*;
#(
   parameter int LOCK_N = 4
) (
   input  logic  clk,
   input  logic  rst,
   input  step_e cmd_i,
   output logic  locked_o
);

   localparam int LW = $clog2(LOCK_N + 1);

   logic          have_q;
   logic          dir_q;
   logic [LW-1:0] rev_q;
   logic          dir;

   assign dir = (cmd_i == STEP_UP);

   always_ff @(posedge clk) begin
      if (rst) begin
         have_q <= 1'b0;
         dir_q  <= 1'b0;
         rev_q  <= '0;
      end else if (cmd_i != STEP_HOLD) begin
         have_q <= 1'b1;
         dir_q  <= dir;
         if (have_q) begin
            if (dir != dir_q) begin
               if (rev_q != LW'(LOCK_N)) rev_q <= rev_q + LW'(1);
            end else begin
               rev_q <= '0;
            end
         end
      end
   end

   assign locked_o = (rev_q == LW'(LOCK_N));

endmodule

// File: rtl/cdr_bb_ctrl.sv
module cdr_bb_ctrl
   import cdr_bb_pkg::*;
#(
   parameter int PW       = 8,
   parameter int CW       = 6,
   parameter int LOCK_N   = 4,
   parameter bit HAS_VOTE = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [PW-1:0] init_code,
   input  logic          vote_en,
   input  logic [CW-1:0] vote_len,
   input  logic [CW-1:0] vote_thresh,
   input  logic          sample_vld,
   input  logic          data_smp,
   input  logic          edge_smp,
   output logic [PW-1:0] phase_code,
   output logic          step_up,
   output logic          step_dn,
   output logic          locked
);

   generate
      if (PW < 2) begin : g_bad_pw
         $error("cdr_bb_ctrl: PW must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("cdr_bb_ctrl: CW must be at least 1");
      end
      if (LOCK_N < 1) begin : g_bad_lock
         $error("cdr_bb_ctrl: LOCK_N must be at least 1");
      end
   endgenerate

   step_e dec;
   logic  dec_vld;
   step_e cmd;

   cdr_bb_detect i_detect (
      .clk       (clk),
      .rst       (rst),
      .vld_i     (sample_vld),
      .data_i    (data_smp),
      .edge_i    (edge_smp),
      .dec_o     (dec),
      .dec_vld_o (dec_vld)
   );

   cdr_bb_vote #(.CW(CW), .HAS_VOTE(HAS_VOTE)) i_vote (
      .clk       (clk),
      .rst       (rst),
      .en_i      (vote_en),
      .len_i     (vote_len),
      .thresh_i  (vote_thresh),
      .dec_vld_i (dec_vld),
      .dec_i     (dec),
      .cmd_o     (cmd)
   );

   cdr_bb_accum #(.PW(PW)) i_accum (
      .clk     (clk),
      .rst     (rst),
      .init_i  (init_code),
      .cmd_i   (cmd),
      .phase_o (phase_code),
      .up_o    (step_up),
      .dn_o    (step_dn)
   );

   cdr_bb_lock #(.LOCK_N(LOCK_N)) i_lock (
      .clk      (clk),
      .rst      (rst),
      .cmd_i    (cmd),
      .locked_o (locked)
   );

endmodule

// File: rtl/cdr_bb_ctrl_chk.sv
module cdr_bb_ctrl_chk #(
   parameter int PW = 8
) (
   input logic          clk,
   input logic          rst,
   input logic [PW-1:0] init_code,
   input logic          sample_vld,
   input logic [PW-1:0] phase_code,
   input logic          step_up,
   input logic          step_dn,
   input logic          locked
);

   a_r12_pulse_excl: assert property (@(posedge clk) disable iff (rst)
      $onehot0({step_up, step_dn}));

   a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (phase_code == $past(init_code)) && !step_up && !step_dn && !locked);

   a_r4_up_plus_one: assert property (@(posedge clk) disable iff (rst)
      (step_up && !$past(rst)) |-> phase_code == PW'($past(phase_code) + PW'(1)));

   a_r5_dn_minus_one: assert property (@(posedge clk) disable iff (rst)
      (step_dn && !$past(rst)) |-> phase_code == PW'($past(phase_code) - PW'(1)));

   a_r12_quiet_hold: assert property (@(posedge clk) disable iff (rst)
      (!step_up && !step_dn && !$past(rst)) |-> $stable(phase_code));

   a_r7_no_strobe_no_step: assert property (@(posedge clk) disable iff (rst)
      (!$past(sample_vld) && !$past(rst)) |-> (!step_up && !step_dn));

endmodule

bind cdr_bb_ctrl cdr_bb_ctrl_chk #(.PW(PW)) i_chk (
   .clk        (clk),
   .rst        (rst),
   .init_code  (init_code),
   .sample_vld (sample_vld),
   .phase_code (phase_code),
   .step_up    (step_up),
   .step_dn    (step_dn),
   .locked     (locked)
);

// File: tb/test_cdr_bb_ctrl.sv
`timescale 1ns/1ps
module test_cdr_bb_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] init_code = 8'd0;
   logic       vote_en = 1'b0;
   logic [5:0] vote_len = 6'd0;
   logic [5:0] vote_thresh = 6'd0;
   logic       sample_vld = 1'b0;
   logic       data_smp = 1'b0;
   logic       edge_smp = 1'b0;
   logic [7:0] phase_code;
   logic       step_up;
   logic       step_dn;
   logic       locked;

   int n_run = 0;
   int n_fail = 0;
   logic prev = 1'b0;

   always #4 clk = ~clk;

   cdr_bb_ctrl i_cdr_bb_ctrl (
      .clk(clk), .rst(rst), .init_code(init_code), .vote_en(vote_en),
      .vote_len(vote_len), .vote_thresh(vote_thresh), .sample_vld(sample_vld),
      .data_smp(data_smp), .edge_smp(edge_smp), .phase_code(phase_code),
      .step_up(step_up), .step_dn(step_dn), .locked(locked)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_state(input string req, input int ph, input bit up, input bit dn);
      check(phase_code == ph[7:0], req, phase_code, ph);
      check(step_up == up && step_dn == dn, req, {step_up, step_dn}, {up, dn});
   endtask

   task automatic do_reset(input logic [7:0] init, input bit ven, input int len, input int thr);
      @(negedge clk);
      rst = 1'b1; sample_vld = 1'b0;
      init_code = init; vote_en = ven; vote_len = 6'(len); vote_thresh = 6'(thr);
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      prev = 1'b0;
   endtask

   // one strobed sample; returns at the negedge after the sampling edge
   task automatic send(input logic d, input logic e);
      @(negedge clk);
      sample_vld = 1'b1; data_smp = d; edge_smp = e;
      @(negedge clk);
      sample_vld = 1'b0;
      prev = d;
   endtask

   task automatic s_up();   send(~prev, prev);  endtask
   task automatic s_dn();   send(~prev, ~prev); endtask
   task automatic s_hold(); send(prev, ~prev);  endtask

   task automatic t_reset();
      do_reset(8'd77, 1'b0, 0, 0);
      chk_state("R1 reset", 77, 0, 0);
      check(locked == 1'b0, "R1 lock cleared", locked, 0);
   endtask

   task automatic t_prime();
      do_reset(8'd40, 1'b0, 0, 0);
      send(1'b1, 1'b0);   // transition vs. reset bit 0 would read as early
      chk_state("R2 first sample no step", 40, 0, 0);
   endtask

   task automatic t_basic();
      do_reset(8'd100, 1'b0, 0, 0);
      send(1'b0, 1'b0);
      s_hold();
      chk_state("R3 no transition hold", 100, 0, 0);
      s_up();
      chk_state("R4 early steps up", 101, 1, 0);
      s_up();
      chk_state("R4 early falling edge", 102, 1, 0);
      s_dn();
      chk_state("R5 late steps down", 101, 0, 1);
      s_dn();
      chk_state("R10 each decision steps", 100, 0, 1);
      @(negedge clk);
      chk_state("R12 pulse is one cycle", 100, 0, 0);
   endtask

   task automatic t_strobe();
      do_reset(8'd10, 1'b0, 0, 0);
      send(1'b0, 1'b0);
      @(negedge clk);
      data_smp = 1'b1; edge_smp = 1'b0; sample_vld = 1'b0;
      @(negedge clk);
      chk_state("R7 no strobe no step", 10, 0, 0);
      send(1'b0, 1'b1);   // holds only if the unstrobed bit was ignored
      chk_state("R7 previous bit kept", 10, 0, 0);
   endtask

   task automatic t_wrap();
      do_reset(8'd255, 1'b0, 0, 0);
      send(1'b0, 1'b0);
      s_up();
      chk_state("R6 wrap up 255->0", 0, 1, 0);
      do_reset(8'd0, 1'b0, 0, 0);
      send(1'b0, 1'b0);
      s_dn();
      chk_state("R6 wrap down 0->255", 255, 0, 1);
   endtask

   task automatic t_vote();
      do_reset(8'd100, 1'b1, 4, 2);
      send(1'b0, 1'b0);
      s_up(); s_up(); s_up();
      chk_state("R8 no step inside window", 100, 0, 0);
      s_hold();
      chk_state("R8 net 3 over 2 steps up", 101, 1, 0);
      s_up(); s_up(); s_hold(); s_hold();
      chk_state("R9 net equal threshold holds", 101, 0, 0);
      s_dn(); s_dn(); s_dn();
      chk_state("R9 window restarted", 101, 0, 0);
      s_dn();
      chk_state("R8 net -4 steps down", 100, 0, 1);
      s_dn(); s_dn(); s_up(); s_hold();
      chk_state("R9 net -1 holds", 100, 0, 0);
   endtask

   task automatic t_lock();
      do_reset(8'd50, 1'b0, 0, 0);
      send(1'b0, 1'b0);
      s_up(); s_dn(); s_up(); s_dn();
      check(locked == 1'b0, "R11 three reversals not locked", locked, 0);
      s_up();
      check(locked == 1'b1, "R11 four reversals lock", locked, 1);
      chk_state("R12 dither phase", 51, 1, 0);
      s_up();
      check(locked == 1'b0, "R11 same direction unlocks", locked, 0);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_prime();
      t_basic();
      t_strobe();
      t_wrap();
      t_vote();
      t_lock();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule